// File: doc/BRIEF.md
# Video Scanning Format Classifier

The block watches the timing strobes of a decoded video stream and reports a 4-bit code for the scanning format it finds. On each clock it may see a start-of-line strobe. Along with it come the vertical-blanking flag and the field flag. A 2-bit frame-rate family estimate and an active-line count come from outside the block. Frames are split at a fixed point in the flag pattern. The block counts the lines in each frame and notes whether field 1 was seen. It then maps the line count, interlace, rate family and active-line count to a code.

The top bit of the code tells progressive (0) from interlaced (1). Each known format has an even code. Formats that match nothing fall to one of two catch-all codes: one for unknown progressive and one for unknown interlaced. A new code takes effect only after two frames in a row give the same result. Until then the output keeps its previous value. After reset the output reads unknown interlaced.

Top module: `video_fmt_classifier`

## Requirements
- R1: After reset the code output is 1111. It keeps that value until two consecutive measured frames give the same classification.
- R2: A frame boundary is a line strobe with the vertical flag low and the field flag low, where the vertical flag was high at the previous line strobe. The line count of a frame is the number of line strobes from one boundary, counted inclusively, up to the next boundary, counted exclusively. The rate and active-line inputs are sampled on the closing boundary.
- R3: A frame is interlaced, and gets bit 3 = 1, when the field flag was high at any line strobe inside it. Otherwise it is progressive, with bit 3 = 0.
- R4: Progressive frames are coded as follows. 750 lines at rate 00 (60 Hz family) gives 0000. 1125 lines gives 0010 at rate 01 (30 Hz), 0100 at rate 10 (25 Hz) and 0110 at rate 11 (24 Hz).
- R5: Interlaced frames are coded as follows. 1125 lines at rate 01 gives 1000 with 1080 active lines and 1110 with 1035 active lines. 1125 lines at rate 10 gives 1010. 1250 lines at rate 10 gives 1100.
- R6: Any other progressive frame gives 0111. Any other interlaced frame gives 1111.
- R7: The output never carries an odd code other than 0111 or 1111.
- R8: The output changes only when a classification equals the one from the frame just before it. Otherwise the previous code is held.
- R9: A confirmed code appears on the output after the second rising clock edge that follows the edge which captured the closing boundary strobe. It has not yet appeared after the first.
- R10: The first boundary after reset only opens a measurement. It produces no classification.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | Start-of-line strobe, one per line |
| vblank | input | 1 | Vertical blanking flag, valid with line_stb |
| field | input | 1 | Field flag, valid with line_stb |
| rate_fam | input | 2 | Frame-rate family: 00=60, 01=30, 10=25, 11=24 Hz |
| act_lines | input | 12 | Active lines per frame |
| fmt_code | output | 4 | Detected format code |

## Verification
A classification comes from the strobe that closes a frame. The register that measures the frame is loaded on that edge, and the held code is loaded on the next one. The bench samples the code on the falling edge that follows the first of these edges and expects the old value. It samples again after the second edge and expects the new value. This pins R9 down on every frame. A bench model of the two-frame confirmation, driven by the frame parameters and an arithmetic code formula, gives both expected values for the sweep over line counts, interlace, rate families and active-line counts.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    localparam int MEAS_W = 12;

    localparam int LINES_720P  = 750;
    localparam int LINES_1125  = 1125;
    localparam int LINES_1250  = 1250;
    localparam int ACT_1080    = 1080;
    localparam int ACT_1035    = 1035;

    typedef enum logic [1:0] {
        RATE_60 = 2'b00,
        RATE_30 = 2'b01,
        RATE_25 = 2'b10,
        RATE_24 = 2'b11
    } rate_e;

    typedef enum logic [3:0] {
        FMT_P750_60   = 4'b0000,
        FMT_P1125_30  = 4'b0010,
        FMT_P1125_25  = 4'b0100,
        FMT_P1125_24  = 4'b0110,
        FMT_P_UNKNOWN = 4'b0111,
        FMT_I1125_30  = 4'b1000,
        FMT_I1125_25  = 4'b1010,
        FMT_I1250_25  = 4'b1100,
        FMT_I1035_30  = 4'b1110,
        FMT_I_UNKNOWN = 4'b1111
    } fmt_code_e;

    typedef struct packed {
        logic              interlaced;
        logic [MEAS_W-1:0] lines;
        logic [1:0]        rate;
        logic [MEAS_W-1:0] act;
    } frame_meas_t;

    // Maps one measured frame to its code (R4, R5, R6)
    function automatic fmt_code_e classify(frame_meas_t m);
        fmt_code_e c;
        if (!m.interlaced) begin
            c = FMT_P_UNKNOWN;
            if (m.lines == MEAS_W'(LINES_720P) && m.rate == RATE_60)
                c = FMT_P750_60;
            else if (m.lines == MEAS_W'(LINES_1125)) begin
                case (m.rate)
                    RATE_30: c = FMT_P1125_30;
                    RATE_25: c = FMT_P1125_25;
                    RATE_24: c = FMT_P1125_24;
                    default: c = FMT_P_UNKNOWN;
                endcase
            end
        end else begin
            c = FMT_I_UNKNOWN;
            if (m.lines == MEAS_W'(LINES_1125) && m.rate == RATE_30) begin
                if (m.act == MEAS_W'(ACT_1080))
                    c = FMT_I1125_30;
                else if (m.act == MEAS_W'(ACT_1035))
                    c = FMT_I1035_30;
            end else if (m.lines == MEAS_W'(LINES_1125) && m.rate == RATE_25)
                c = FMT_I1125_25;
            else if (m.lines == MEAS_W'(LINES_1250) && m.rate == RATE_25)
                c = FMT_I1250_25;
        end
        return c;
    endfunction

endpackage

// File: rtl/frame_meter.sv
module frame_meter
    import fmt_pkg::*;
#(
    parameter int LINE_W = MEAS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_stb,
    input  logic              vblank,
    input  logic              field,
    input  logic [1:0]        rate_fam,
    input  logic [LINE_W-1:0] act_lines,
    output frame_meas_t       meas_o,
    output logic              meas_vld_o
);

    localparam logic [LINE_W-1:0] CNT_MAX = '1;

    logic              prev_vb_q;
    logic              open_q;
    logic              saw_f1_q;
    logic [LINE_W-1:0] cnt_q;
    logic              boundary;

    // R2: end of vertical blanking while the field flag is low
    assign boundary = line_stb && !vblank && !field && prev_vb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_vb_q  <= 1'b0;
            open_q     <= 1'b0;
            saw_f1_q   <= 1'b0;
            cnt_q      <= '0;
            meas_vld_o <= 1'b0;
            meas_o     <= '0;
        end else begin
            meas_vld_o <= 1'b0;
            if (line_stb) begin
                prev_vb_q <= vblank;
                if (boundary) begin
                    // R10: the first boundary only opens a measurement
                    if (open_q) begin
                        meas_o.interlaced <= saw_f1_q;
                        meas_o.lines      <= MEAS_W'(cnt_q);
                        meas_o.rate       <= rate_fam;
                        meas_o.act        <= MEAS_W'(act_lines);
                        meas_vld_o        <= 1'b1;
                    end
                    open_q   <= 1'b1;
                    cnt_q    <= LINE_W'(1);
                    saw_f1_q <= 1'b0;
                end else begin
                    if (cnt_q != CNT_MAX)
                        cnt_q <= cnt_q + LINE_W'(1);
                    if (field)
                        saw_f1_q <= 1'b1;   // R3
                end
            end
        end
    end

    // R9: a measurement is only produced by a captured line strobe
    a_r9_meas_after_strobe: assert property (@(posedge clk) disable iff (rst)
        meas_vld_o |-> $past(line_stb));

endmodule

// File: rtl/fmt_classify.sv
module fmt_classify
    import fmt_pkg::*;
(
    input  frame_meas_t meas_i,
    input  logic        meas_vld_i,
    output fmt_code_e   cls_o,
    output logic        cls_vld_o
);

    assign cls_o     = classify(meas_i);
    assign cls_vld_o = meas_vld_i;

endmodule

// File: rtl/code_hold.sv
module code_hold
    import fmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fmt_code_e cls_i,
    input  logic      cls_vld_i,
    output logic [3:0] code_o
);

    fmt_code_e cand_q;
    logic      cand_vld_q;
    fmt_code_e code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q     <= FMT_I_UNKNOWN;
            cand_vld_q <= 1'b0;
            code_q     <= FMT_I_UNKNOWN;   // R1
        end else if (cls_vld_i) begin
            // R8: two matching frames in a row confirm a code
            if (cand_vld_q && cls_i == cand_q)
                code_q <= cls_i;
            cand_q     <= cls_i;
            cand_vld_q <= 1'b1;
        end
    end

    assign code_o = code_q;

    a_r1_reset_unknown: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> code_q == FMT_I_UNKNOWN);

    a_r7_no_reserved: assert property (@(posedge clk) disable iff (rst)
        code_o[0] |-> code_o[2:1] == 2'b11);

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !cls_vld_i |=> $stable(code_q));

endmodule

// File: rtl/video_fmt_classifier.sv
module video_fmt_classifier
    import fmt_pkg::*;
#(
    parameter int LINE_W = MEAS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_stb,
    input  logic              vblank,
    input  logic              field,
    input  logic [1:0]        rate_fam,
    input  logic [LINE_W-1:0] act_lines,
    output logic [3:0]        fmt_code
);

    frame_meas_t meas;
    logic        meas_vld;
    fmt_code_e   cls;
    logic        cls_vld;

    frame_meter #(.LINE_W(LINE_W)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .line_stb   (line_stb),
        .vblank     (vblank),
        .field      (field),
        .rate_fam   (rate_fam),
        .act_lines  (act_lines),
        .meas_o     (meas),
        .meas_vld_o (meas_vld)
    );

    fmt_classify u_classify (
        .meas_i     (meas),
        .meas_vld_i (meas_vld),
        .cls_o      (cls),
        .cls_vld_o  (cls_vld)
    );

    code_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .cls_i     (cls),
        .cls_vld_i (cls_vld),
        .code_o    (fmt_code)
    );

endmodule

// File: tb/test_video_fmt_classifier.sv
module test_video_fmt_classifier;

    localparam int VB = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_stb = 1'b0;
    logic        vblank = 1'b0;
    logic        field = 1'b0;
    logic [1:0]  rate_fam = 2'b00;
    logic [11:0] act_lines = 12'd1080;
    logic [3:0]  fmt_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model state
    bit         have_vb = 1'b0;
    bit         opened  = 1'b0;
    bit         cand_v  = 1'b0;
    logic [3:0] cand    = 4'hF;
    logic [3:0] mout    = 4'hF;
    int         p_lines, p_rate, p_act;
    bit         p_il;

    always #4 clk = ~clk;

    video_fmt_classifier i_video_fmt_classifier (
        .clk(clk), .rst(rst), .line_stb(line_stb), .vblank(vblank),
        .field(field), .rate_fam(rate_fam), .act_lines(act_lines),
        .fmt_code(fmt_code)
    );

    function automatic logic [3:0] exp_code(int l, bit il, int r, int a);
        if (!il) begin
            if (l == 750 && r == 0) return 4'b0000;          // R4
            if (l == 1125 && r > 0) return 4'(2 * r);         // R4
            return 4'b0111;                                   // R6
        end
        if (l == 1125 && r == 1 && a == 1080) return 4'b1000; // R5
        if (l == 1125 && r == 1 && a == 1035) return 4'b1110; // R5
        if (l == 1125 && r == 2) return 4'b1010;              // R5
        if (l == 1250 && r == 2) return 4'b1100;              // R5
        return 4'b1111;                                       // R6
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: fmt_code=%b expected=%b", req, act, exp);
        end
    endtask

    // One frame of continuous line strobes; checks timing of each update
    task automatic send_frame(int l, bit il, int r, int a);
        logic [3:0] old_e, new_e;
        string tag;
        int half = l / 2;
        old_e = mout;
        tag = "R1";
        if (have_vb) begin
            if (opened) begin
                new_e = exp_code(p_lines, p_il, p_rate, p_act);
                if (cand_v && new_e == cand) mout = new_e;   // R8
                cand = new_e;
                cand_v = 1'b1;
                if (mout != old_e)
                    tag = mout[3] ? "R3 R5 R6" : "R2 R4 R6";
                else
                    tag = "R8";
            end else begin
                opened = 1'b1;
                tag = "R10";
            end
        end
        new_e = mout;
        for (int k = 0; k < l; k++) begin
            @(negedge clk);
            if (k == 1) chk("R9", fmt_code, old_e);
            if (k == 2) begin
                chk(tag, fmt_code, new_e);
                n_checks++;
                if (fmt_code[0] && fmt_code[2:1] != 2'b11) begin
                    n_fail++;
                    $display("FAIL R7: fmt_code=%b expected=x11x-or-even", fmt_code);
                end
            end
            if (k == 1) begin
                rate_fam  = 2'(r);
                act_lines = 12'(a);
            end
            line_stb = 1'b1;
            if (il) begin
                field  = (k >= half);
                vblank = (k >= half - VB && k < half) || (k >= l - VB);
            end else begin
                field  = 1'b0;
                vblank = (k >= l - VB);
            end
        end
        have_vb = 1'b1;
        p_lines = l; p_il = il; p_rate = r; p_act = a;
    endtask

    task automatic run_combo(int l, bit il, int r, int a);
        for (int f = 0; f < 3; f++) send_frame(l, il, r, a);
    endtask

    initial begin
        int lset[4];
        lset = '{750, 1125, 1250, 1000};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", fmt_code, 4'hF);
        // primer: no boundary, opening boundary, first classification
        run_combo(1125, 1'b0, 1, 1080);
        for (int li = 0; li < 4; li++)
            for (int il = 0; il < 2; il++)
                for (int r = 0; r < 4; r++)
                    run_combo(lset[li], il[0], r, 1080);
        // R5: active-line count separates the two 1125-line 30 Hz interlaced codes
        run_combo(1125, 1'b1, 1, 1035);
        run_combo(1125, 1'b1, 1, 720);
        run_combo(1125, 1'b1, 1, 1080);
        send_frame(750, 1'b0, 0, 1080);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule